// File: doc/BRIEF.md
# Three-Wire Configuration Port with Strap Defaults

This block is the configuration front end of a radio transceiver control core. Software or a host writes it through three plain wires: a serial clock, a serial data line and an enable line. Every rising serial clock edge shifts one data bit into a 24-bit frame register. A rising enable edge then commits that frame. The two leading bits of the frame pick one of four 22-bit configuration words, and the remaining 22 bits become the new contents of that word. The three serial wires are asynchronous to the core clock. The block brings them into the core clock domain through a parameterised synchronizer and acts on the edges it detects there.

The enable wire also serves as a strap. Together with a second strap pin, its level during reset selects one of four frequency plans. These plans seed the four words with default divider values, so the core can run with no serial traffic at all. The block starts in this stand-alone mode. The first time the enable wire leaves its strapped level, the block switches to programmable mode, and it stays there until the next reset. The serial wires and the configuration words are plain level signals with no handshake. The serial protocol is the only flow control: a word changes only when the host raises the enable line.

Top module: `cfg_serial_port`

## Requirements
- R1: Each rising edge of `ser_clk` shifts the level of `ser_data` into bit 0 of the frame register, and the older bits move one place up. The first bit sent therefore ends up as frame bit 23 (most significant bit first).
- R2: The frame register is 24 bits wide. When more than 24 bits are clocked in before a commit, the bits sent first drop out and only the last 24 count.
- R3: A rising edge of `ser_en` copies frame bits 21:0 into the word selected by frame bits 23:22: 00 selects `word_a`, 01 `word_b`, 10 `word_c` and 11 `word_d`.
- R4: A commit changes only the selected word. The other three words keep their values.
- R5: While reset is asserted, the words take defaults from strap = {`strap_fs1`, `ser_en`}. Field positions: `word_a`[9:0] and `word_b`[9:0] hold the reference divider. `word_c`[16:0] holds the receive feedback divider, `word_c`[17] the band bit and `word_c`[19:18] the oscillator current. `word_d`[16:0] holds the transmit feedback divider. All other bits are 0, except the bits named in R6. The straps give the following values, in the order reference divider / receive / transmit / band / current: strap 00 gives 16/1919/1943/1/3; strap 01 gives 32/1894/1942/0/1; strap 10 gives 32/4047/4095/1/3; strap 11 gives 18/766/793/0/0.
- R6: Bit 13 of `word_a` and bit 20 of `word_b` always read 1, both after reset and after any write, including a write that sends 0 in those positions.
- R7: `prog_mode` is 0 after reset. It becomes 1 once `ser_en` differs from the level it had during reset. From then on it stays 1 until the next reset.
- R8: The straps are taken only during reset. After reset, changing `strap_fs1` has no effect on any word.
- R9: In stand-alone mode, while `ser_en` stays at its strapped level, activity on `ser_clk` and `ser_data` leaves all four words unchanged.
- R10: A falling edge of `ser_en` commits nothing. All words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low; the straps are taken while it is low |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Commit strobe, rising edge active; also strap bit 0 during reset |
| strap_fs1 | input | 1 | Strap bit 1, used only during reset |
| prog_mode | output | 1 | 1 once programmable mode has been entered |
| word_a | output | 22 | Configuration word, address 00 |
| word_b | output | 22 | Configuration word, address 01 |
| word_c | output | 22 | Configuration word, address 10 |
| word_d | output | 22 | Configuration word, address 11 |

## Verification
The assertions assume that each serial wire holds a level for more core clock periods than the synchronizer depth plus one, so that every edge is seen exactly once. They also assume that `ser_data` is steady around each rising `ser_clk` edge. The stimulus keeps each serial level for four core clocks and changes data only while `ser_clk` is low. It raises `ser_en` only after the last clock pulse of a frame has settled. Reset is held for several cycles with the straps already at their final levels.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int WORD_W    = 22;
  localparam int ADDR_W    = 2;
  localparam int FRAME_W   = WORD_W + ADDR_W;
  localparam int NUM_WORDS = 1 << ADDR_W;
  localparam int RSV_A_BIT = 13;
  localparam int RSV_B_BIT = 20;

  typedef logic [WORD_W-1:0] cfg_word_t;
  typedef cfg_word_t [NUM_WORDS-1:0] cfg_bank_t;

  // bits that are tied high in each word
  function automatic cfg_word_t force_mask(input int idx);
    cfg_word_t m;
    m = '0;
    if (idx == 0) m[RSV_A_BIT] = 1'b1;
    if (idx == 1) m[RSV_B_BIT] = 1'b1;
    return m;
  endfunction

  function automatic cfg_bank_t strap_defaults(input logic [1:0] strap);
    logic [9:0]  rdiv;
    logic [16:0] nrx;
    logic [16:0] ntx;
    logic        band;
    logic [1:0]  vcur;
    cfg_bank_t   b;
    case (strap)
      2'b00:   begin rdiv = 10'd16; nrx = 17'd1919; ntx = 17'd1943; band = 1'b1; vcur = 2'd3; end
      2'b01:   begin rdiv = 10'd32; nrx = 17'd1894; ntx = 17'd1942; band = 1'b0; vcur = 2'd1; end
      2'b10:   begin rdiv = 10'd32; nrx = 17'd4047; ntx = 17'd4095; band = 1'b1; vcur = 2'd3; end
      default: begin rdiv = 10'd18; nrx = 17'd766;  ntx = 17'd793;  band = 1'b0; vcur = 2'd0; end
    endcase
    b = '0;
    b[0][9:0]   = rdiv;
    b[1][9:0]   = rdiv;
    b[2][16:0]  = nrx;
    b[2][17]    = band;
    b[2][19:18] = vcur;
    b[3][16:0]  = ntx;
    for (int i = 0; i < NUM_WORDS; i++) b[i] = b[i] | force_mask(i);
    return b;
  endfunction
endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        stage_q[0] <= din;
      end
    end else begin : g_next
      // during reset every stage follows the pin so no edge appears on release
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= din;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_shift.sv
module cfg_frame_shift
  import cfg_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdata_s,
  output logic [FRAME_W-1:0] frame_q
);
  logic sclk_prev_q;
  logic sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_prev_q <= sclk_s;
      frame_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      if (sclk_rise) frame_q <= {frame_q[FRAME_W-2:0], sdata_s};
    end
  end

  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (frame_q[0] == $past(sdata_s)));

  assert_older_bits_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0])));
endmodule

// File: rtl/cfg_mode_ctl.sv
module cfg_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_s,
  output logic commit,
  output logic prog_mode_q
);
  logic sen_prev_q;
  logic strap0_q;
  logic left_strap;

  assign commit     = sen_s & ~sen_prev_q;
  assign left_strap = (sen_s != strap0_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sen_prev_q  <= sen_s;
      strap0_q    <= sen_s;
      prog_mode_q <= 1'b0;
    end else begin
      sen_prev_q <= sen_s;
      if (left_strap) prog_mode_q <= 1'b1;
    end
  end

  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode_q |=> prog_mode_q);

  assert_commit_implies_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> prog_mode_q);

  assert_strap_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap0_q));
endmodule

// File: rtl/cfg_word_bank.sv
module cfg_word_bank
  import cfg_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         strap_live,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame,
  output cfg_bank_t          bank_q
);
  cfg_bank_t             dflt;
  logic [ADDR_W-1:0]     sel;
  cfg_word_t             payload;
  logic [NUM_WORDS-1:0]  load_vec;

  assign dflt    = strap_defaults(strap_live);
  assign sel     = frame[FRAME_W-1 -: ADDR_W];
  assign payload = frame[WORD_W-1:0];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam cfg_word_t TIE_HIGH = force_mask(i);

    assign load_vec[i] = commit && (sel == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)           bank_q[i] <= dflt[i];
      else if (load_vec[i]) bank_q[i] <= payload | TIE_HIGH;
    end

    assert_untouched_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_vec[i] |=> $stable(bank_q[i]));

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_vec[i] |=> ((bank_q[i] & ~TIE_HIGH) == ($past(frame[WORD_W-1:0]) & ~TIE_HIGH)));
  end

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  assert_reserved_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q[0][RSV_A_BIT] && bank_q[1][RSV_B_BIT]);
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              strap_fs1,
  output logic              prog_mode,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic [WORD_W-1:0] word_c,
  output logic [WORD_W-1:0] word_d
);
  localparam int NPINS = 4;

  logic [NPINS-1:0]   pins_s;
  logic [FRAME_W-1:0] frame;
  logic               commit;
  cfg_bank_t          bank;

  cfg_in_sync #(.STAGES(SYNC_STAGES), .W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({strap_fs1, ser_en, ser_data, ser_clk}),
    .dout (pins_s)
  );

  cfg_frame_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (pins_s[0]),
    .sdata_s(pins_s[1]),
    .frame_q(frame)
  );

  cfg_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .sen_s      (pins_s[2]),
    .commit     (commit),
    .prog_mode_q(prog_mode)
  );

  cfg_word_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_live(pins_s[3:2]),
    .commit    (commit),
    .frame     (frame),
    .bank_q    (bank)
  );

  assign word_a = bank[0];
  assign word_b = bank[1];
  assign word_c = bank[2];
  assign word_d = bank[3];
endmodule

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic ser_en = 1'b0;
  logic strap_fs1 = 1'b0;
  logic prog_mode;
  logic [21:0] word_a, word_b, word_c, word_d;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  logic [21:0] exp_w [4];

  localparam int HALF = 4;

  always #5 clk = ~clk;

  cfg_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .strap_fs1(strap_fs1), .prog_mode(prog_mode),
    .word_a(word_a), .word_b(word_b), .word_c(word_c), .word_d(word_d)
  );

  function automatic logic [21:0] dflt(input int s, input int idx);
    logic [21:0] w;
    int rd, nr, nt, bd, vc;
    case (s)
      0: begin rd = 16; nr = 1919; nt = 1943; bd = 1; vc = 3; end
      1: begin rd = 32; nr = 1894; nt = 1942; bd = 0; vc = 1; end
      2: begin rd = 32; nr = 4047; nt = 4095; bd = 1; vc = 3; end
      default: begin rd = 18; nr = 766; nt = 793; bd = 0; vc = 0; end
    endcase
    w = '0;
    case (idx)
      0: begin w[9:0] = rd[9:0]; w[13] = 1'b1; end
      1: begin w[9:0] = rd[9:0]; w[20] = 1'b1; end
      2: begin w[16:0] = nr[16:0]; w[17] = bd[0]; w[19:18] = vc[1:0]; end
      default: w[16:0] = nt[16:0];
    endcase
    return w;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, {10'd0, word_a}, {10'd0, exp_w[0]});
    chk(req, {10'd0, word_b}, {10'd0, exp_w[1]});
    chk(req, {10'd0, word_c}, {10'd0, exp_w[2]});
    chk(req, {10'd0, word_d}, {10'd0, exp_w[3]});
  endtask

  task automatic do_reset(input int s);
    rst_n = 1'b0;
    ser_clk = 1'b0;
    ser_data = 1'b0;
    strap_fs1 = s[1];
    ser_en = s[0];
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(4);
    for (int i = 0; i < 4; i++) exp_w[i] = dflt(s, i);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      wait_clk(HALF);
      ser_clk = 1'b1;
      wait_clk(HALF);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  // enable low, shift, enable high (commit); model updates the target word
  task automatic write_frame(input logic [31:0] bits, input int n);
    logic [21:0] v;
    int a;
    ser_en = 1'b0;
    wait_clk(HALF);
    shift_bits(bits, n);
    ser_en = 1'b1;
    wait_clk(8);
    a = int'(bits[23:22]);
    v = bits[21:0];
    if (a == 0) v[13] = 1'b1;
    if (a == 1) v[20] = 1'b1;
    exp_w[a] = v;
  endtask

  task automatic t_reset_defaults;
    for (int s = 0; s < 4; s++) begin
      do_reset(s);
      chk_all("R5 strap defaults");
      chk("R7 prog_mode after reset", {31'd0, prog_mode}, 32'd0);
      chk("R6 reserved bits", {30'd0, word_a[13], word_b[20]}, 32'd3);
    end
  endtask

  task automatic t_standalone_ignore;
    do_reset(1);
    shift_bits(32'hFFFF_FFFF, 24);
    shift_bits(32'h00A5_5A3C, 24);
    chk_all("R9 standalone serial activity ignored");
    chk("R9 prog_mode stays 0", {31'd0, prog_mode}, 32'd0);
  endtask

  task automatic t_strap_capture;
    do_reset(0);
    strap_fs1 = 1'b1;
    wait_clk(10);
    chk_all("R8 strap change after reset ignored");
  endtask

  task automatic t_enter_prog_falling;
    do_reset(1);
    shift_bits(32'h00C0_0001, 24);
    ser_en = 1'b0;
    wait_clk(8);
    chk("R7 first change enters prog", {31'd0, prog_mode}, 32'd1);
    chk_all("R10 falling edge commits nothing");
  endtask

  task automatic t_write_each;
    do_reset(2);
    write_frame({8'd0, 2'b00, 22'h2A_5C31}, 24);
    chk_all("R1 R3 write word A msb first");
    write_frame({8'd0, 2'b01, 22'h15_0F0F}, 24);
    chk_all("R3 R4 write word B");
    write_frame({8'd0, 2'b10, 22'h3F_FFFF}, 24);
    chk_all("R3 R4 write word C");
    write_frame({8'd0, 2'b11, 22'h00_0001}, 24);
    chk_all("R3 R4 write word D");
    chk("R7 sticky after writes", {31'd0, prog_mode}, 32'd1);
  endtask

  task automatic t_overlong;
    do_reset(3);
    write_frame({8'hFF, 2'b10, 22'h12_3456}, 32);
    chk_all("R2 only last 24 bits count");
    write_frame({8'h80, 2'b11, 22'h0A_BCDE}, 30);
    chk_all("R2 leading bits dropped");
  endtask

  task automatic t_reserved;
    do_reset(0);
    write_frame({8'd0, 2'b00, 22'h00_0000}, 24);
    chk("R6 word_a bit13 forced", {31'd0, word_a[13]}, 32'd1);
    write_frame({8'd0, 2'b01, 22'h00_0000}, 24);
    chk("R6 word_b bit20 forced", {31'd0, word_b[20]}, 32'd1);
    chk_all("R6 R4 reserved write results");
  endtask

  task automatic t_rise_first;
    do_reset(0);
    shift_bits({8'd0, 2'b11, 22'h1B_0C0D}, 24);
    ser_en = 1'b1;
    wait_clk(8);
    exp_w[3] = 22'h1B_0C0D;
    chk("R7 rising first change enters prog", {31'd0, prog_mode}, 32'd1);
    chk_all("R3 first rise commits frame");
    ser_en = 1'b0;
    wait_clk(8);
    chk("R7 prog stays set", {31'd0, prog_mode}, 32'd1);
    chk_all("R10 fall after commit no change");
  endtask

  initial begin
    t_reset_defaults();
    t_standalone_ignore();
    t_strap_capture();
    t_enter_prog_falling();
    t_write_each();
    t_overlong();
    t_reserved();
    t_rise_first();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule